// File: doc/BRIEF.md
# Interrupt Request Output Controller

This block drives an active-low interrupt request line for a peripheral that reports events through two status registers. Each event strobe is qualified by its own mask bit. Only qualified events are latched into a status register, and only they raise a request. A host-side decoder, which is outside this block, presents plain strobes: one read strobe per status register and one software interrupt-reset strobe. The host also supplies two static configuration bits.

The first configuration bit selects how the request appears on the line. In pulse mode, a qualified event produces one low pulse of fixed width. The width is 500 ns expressed in clock cycles. In level mode, the line goes low and stays low until it is cleared. A held level clears on the software reset strobe. It also clears when the second configuration bit, auto-clear, is set and the host has read every status register that holds pending bits. An auto-clear read returns the register's contents on the status port and empties that register.

Top module: `irq_out_ctrl`

## Requirements
- R1: While and directly after `rst` is high, `irq_n` is 1 and every status bit reads 0.
- R2: Bit j of status register i (port bit i*EVT_W+j) becomes 1 only when the matching `evt` bit and `mask` bit are both 1 in the same cycle. An event whose mask bit is 0 is not latched and leaves `irq_n` high.
- R3: With `cfg_level`=0, a qualified event sampled on a clock edge drives `irq_n` low from that edge for exactly PULSE_CYC cycles. PULSE_CYC is PULSE_NS/CLK_NS rounded up, which is 25 at the defaults of 500 ns and 20 ns.
- R4: A qualified event that arrives while a pulse is running neither lengthens that pulse nor causes a later pulse. The event is still latched in its status register.
- R5: With `cfg_level`=1, a qualified event drives `irq_n` low. The line stays low until one of the clearing conditions in R6 or R8 occurs.
- R6: A cycle with `irq_rst_stb`=1 returns a held level to high on the next edge. If a qualified event arrives in that same cycle, the event wins and the line stays low.
- R7: When `cfg_autoclr`=1, a read strobe on a register clears that register's latched bits. When `cfg_autoclr`=0, read strobes change no status bit.
- R8: With auto-clear on, a held level returns high only after the reads have emptied every status register. If both registers have pending bits, reading only one of them keeps `irq_n` low.
- R9: A qualified event that arrives in the same cycle as an auto-clear read of its own register survives that read. The event stays latched and keeps a level request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_level | input | 1 | 0 = pulse output, 1 = held level output |
| cfg_autoclr | input | 1 | 1 = status reads clear bits and may release the level |
| irq_rst_stb | input | 1 | Software interrupt-reset strobe |
| evt | input | NUM_REG*EVT_W | Event strobes, register i in bits [i*EVT_W +: EVT_W] |
| mask | input | NUM_REG*EVT_W | Enable bits, same layout as `evt` |
| rd_stb | input | NUM_REG | Read strobe per status register |
| stat | output | NUM_REG*EVT_W | Current status register contents |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The critical collisions are a new qualified event landing in the same cycle as a release. One case pairs the event with a software reset strobe. The other pairs it with an auto-clear read of the register that receives the event. The bench raises the event and the release strobe on the same falling edge. It then expects the line to stay low and the new bit to remain latched. Every cycle is also compared with a behavioural reference model, and that model resolves both collisions in favour of the event.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned DEF_EVT_W    = 16;
    localparam int unsigned DEF_NUM_REG  = 2;
    localparam int unsigned DEF_CLK_NS   = 20;
    localparam int unsigned DEF_PULSE_NS = 500;

    typedef enum logic {
        OUT_PULSE = 1'b0,
        OUT_LEVEL = 1'b1
    } irq_mode_e;

    // Per-register summary handed from a status bank to the combiner.
    typedef struct packed {
        logic any_hit;   // a qualified event arrives this cycle
        logic read_clr;  // an auto-clear read happens this cycle
        logic empty_nxt; // register holds no bit after this edge
    } bank_sum_t;

    function automatic int unsigned ceil_div(input int unsigned num,
                                             input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_pkg::*;
#(
    parameter int unsigned EVT_W = DEF_EVT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] mask,
    input  logic             rd_stb,
    input  logic             autoclr,
    output logic [EVT_W-1:0] stat_q,
    output bank_sum_t        sum
);

    logic [EVT_W-1:0] hit;
    logic [EVT_W-1:0] stat_d;
    logic             clr_now;

    always_comb begin
        hit     = evt & mask;
        clr_now = rd_stb & autoclr;
        // New events are merged after the clear so they survive a read.
        stat_d  = (clr_now ? '0 : stat_q) | hit;
        sum.any_hit   = |hit;
        sum.read_clr  = clr_now;
        sum.empty_nxt = (stat_d == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

endmodule

// File: rtl/irq_pulse_timer.sv
module irq_pulse_timer #(
    parameter int unsigned PULSE_CYC = 25,
    localparam int unsigned CNT_W    = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic trig,
    output logic busy
);

    localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !enable)    remain <= '0;
        else if (remain != '0) remain <= remain - 1'b1; // triggers ignored
        else if (trig)         remain <= LOAD;
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/irq_level_latch.sv
module irq_level_latch (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic set,
    input  logic sw_clr,
    input  logic auto_clr,
    output logic active
);

    always_ff @(posedge clk) begin
        if (rst || !enable)         active <= 1'b0;
        else if (set)               active <= 1'b1;
        else if (sw_clr || auto_clr) active <= 1'b0;
    end

endmodule

// File: rtl/irq_out_ctrl.sv
module irq_out_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned EVT_W    = DEF_EVT_W,
    parameter int unsigned NUM_REG  = DEF_NUM_REG,
    parameter int unsigned CLK_NS   = DEF_CLK_NS,
    parameter int unsigned PULSE_NS = DEF_PULSE_NS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_level,
    input  logic                     cfg_autoclr,
    input  logic                     irq_rst_stb,
    input  logic [NUM_REG*EVT_W-1:0] evt,
    input  logic [NUM_REG*EVT_W-1:0] mask,
    input  logic [NUM_REG-1:0]       rd_stb,
    output logic [NUM_REG*EVT_W-1:0] stat,
    output logic                     irq_n
);

    localparam int unsigned PULSE_CYC = ceil_div(PULSE_NS, CLK_NS);

    bank_sum_t sums [NUM_REG];
    logic      any_hit, any_read, all_empty;
    logic      lvl_active, pls_busy;
    irq_mode_e mode;

    assign mode = irq_mode_e'(cfg_level);

    for (genvar g = 0; g < NUM_REG; g++) begin : g_bank
        irq_status_bank #(.EVT_W(EVT_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt[g*EVT_W +: EVT_W]),
            .mask    (mask[g*EVT_W +: EVT_W]),
            .rd_stb  (rd_stb[g]),
            .autoclr (cfg_autoclr),
            .stat_q  (stat[g*EVT_W +: EVT_W]),
            .sum     (sums[g])
        );
    end

    always_comb begin
        any_hit   = 1'b0;
        any_read  = 1'b0;
        all_empty = 1'b1;
        for (int i = 0; i < NUM_REG; i++) begin
            any_hit   = any_hit   | sums[i].any_hit;
            any_read  = any_read  | sums[i].read_clr;
            all_empty = all_empty & sums[i].empty_nxt;
        end
    end

    irq_level_latch u_level (
        .clk      (clk),
        .rst      (rst),
        .enable   (mode == OUT_LEVEL),
        .set      (any_hit),
        .sw_clr   (irq_rst_stb),
        .auto_clr (any_read & all_empty),
        .active   (lvl_active)
    );

    irq_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .enable (mode == OUT_PULSE),
        .trig   (any_hit),
        .busy   (pls_busy)
    );

    assign irq_n = ~(lvl_active | pls_busy);

endmodule

// File: rtl/irq_out_ctrl_chk.sv
module irq_out_ctrl_chk #(
    parameter int unsigned EVT_W     = 16,
    parameter int unsigned NUM_REG   = 2,
    parameter int unsigned PULSE_CYC = 25
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cfg_level,
    input logic                     cfg_autoclr,
    input logic                     irq_rst_stb,
    input logic [NUM_REG*EVT_W-1:0] evt,
    input logic [NUM_REG*EVT_W-1:0] mask,
    input logic [NUM_REG-1:0]       rd_stb,
    input logic [NUM_REG*EVT_W-1:0] stat,
    input logic                     irq_n
);

    logic        armed;
    int unsigned low_run;
    logic        lvl_in_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            low_run    <= 0;
            lvl_in_run <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (irq_n) begin
                low_run    <= 0;
                lvl_in_run <= 1'b0;
            end else begin
                low_run    <= low_run + 1;
                lvl_in_run <= lvl_in_run | cfg_level;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (irq_n && stat == '0));

    assert_only_masked_latch_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        ((stat & ~$past(stat)) & ~$past(evt & mask)) == '0);

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        ($rose(irq_n) && !lvl_in_run && !$past(cfg_level)) |-> (low_run == PULSE_CYC));

    assert_level_held_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (cfg_level && !irq_n && !irq_rst_stb && !(cfg_autoclr && |rd_stb))
        |=> (!irq_n || !cfg_level));

    assert_sw_clear_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        (cfg_level && irq_rst_stb && (evt & mask) == '0) |=> irq_n);

    assert_no_clear_without_autoclr_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        !cfg_autoclr |=> (($past(stat) & ~stat) == '0));

    assert_level_release_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        ($rose(irq_n) && cfg_level && $past(cfg_level))
        |-> ($past(irq_rst_stb) || ($past(cfg_autoclr && |rd_stb) && stat == '0)));

endmodule

bind irq_out_ctrl irq_out_ctrl_chk #(
    .EVT_W(EVT_W), .NUM_REG(NUM_REG), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .cfg_autoclr(cfg_autoclr),
    .irq_rst_stb(irq_rst_stb), .evt(evt), .mask(mask), .rd_stb(rd_stb),
    .stat(stat), .irq_n(irq_n)
);

// File: tb/irq_out_ctrl_bench.sv
module irq_out_ctrl_bench;

    localparam int W  = 16;
    localparam int NR = 2;
    localparam int PW = 25; // 500 ns / 20 ns

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_level = 1'b0;
    logic            cfg_autoclr = 1'b0;
    logic            irq_rst_stb = 1'b0;
    logic [NR*W-1:0] evt = '0;
    logic [NR*W-1:0] mask = '0;
    logic [NR-1:0]   rd_stb = '0;
    logic [NR*W-1:0] stat;
    logic            irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_out_ctrl u_irq_out_ctrl (
        .clk(clk), .rst(rst), .cfg_level(cfg_level), .cfg_autoclr(cfg_autoclr),
        .irq_rst_stb(irq_rst_stb), .evt(evt), .mask(mask), .rd_stb(rd_stb),
        .stat(stat), .irq_n(irq_n)
    );

    // Behavioural reference: pending words, a countdown and a level flag.
    logic [W-1:0] m_stat [NR];
    int           m_left;
    bit           m_lvl;

    always @(posedge clk) begin
        logic [W-1:0] hit;
        bit any, any_rd, empty;
        any = 0; any_rd = 0; empty = 1;
        if (rst) begin
            for (int i = 0; i < NR; i++) m_stat[i] = '0;
            m_left = 0; m_lvl = 0;
        end else begin
            for (int i = 0; i < NR; i++) begin
                hit = evt[i*W +: W] & mask[i*W +: W];
                if (hit != 0) any = 1;
                if (cfg_autoclr && rd_stb[i]) begin
                    any_rd = 1;
                    m_stat[i] = hit;
                end else m_stat[i] = m_stat[i] | hit;
                if (m_stat[i] != 0) empty = 0;
            end
            if (!cfg_level) m_lvl = 0;
            else if (any) m_lvl = 1;
            else if (irq_rst_stb || (any_rd && empty)) m_lvl = 0;
            if (cfg_level) m_left = 0;
            else if (m_left > 0) m_left = m_left - 1;
            else if (any) m_left = PW;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done && $time > 20) begin
            chk(irq_n == !(m_lvl || m_left > 0), "R3/R5", "model irq_n",
                longint'(irq_n), longint'(!(m_lvl || m_left > 0)));
            for (int i = 0; i < NR; i++)
                chk(stat[i*W +: W] == m_stat[i], "R2/R7", "model stat",
                    longint'(stat[i*W +: W]), longint'(m_stat[i]));
        end
    end

    task automatic do_reset();
        rst = 1'b1; evt = '0; rd_stb = '0; irq_rst_stb = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fire(input int r, input int b);
        evt[r*W + b] = 1'b1;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input int r);
        rd_stb[r] = 1'b1;
        @(negedge clk);
        rd_stb = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int n;
        @(negedge clk);
        do_reset();
        // R1: reset state
        chk(irq_n == 1'b1, "R1", "irq_n after reset", irq_n, 1);
        chk(stat == '0, "R1", "stat after reset", stat, 0);

        // R2: masked-off event ignored
        mask = '0; mask[3] = 1'b1;
        fire(0, 5);
        chk(irq_n == 1'b1, "R2", "irq_n for masked event", irq_n, 1);
        chk(stat == '0, "R2", "stat for masked event", stat, 0);
        repeat (3) @(negedge clk);

        // R3: pulse width, start right after the sampling edge
        fire(0, 3);
        chk(irq_n == 1'b0, "R3", "pulse start", irq_n, 0);
        chk(stat[3] == 1'b1, "R2", "enabled bit latched", stat[3], 1);
        n = 0;
        for (int c = 0; c < 40; c++) begin
            if (!irq_n) n++;
            @(negedge clk);
        end
        chk(n == PW, "R3", "pulse length", n, PW);

        // R4: event inside a pulse
        do_reset();
        mask = '1;
        fire(0, 0);
        n = 0;
        for (int c = 0; c < 70; c++) begin
            if (!irq_n) n++;
            if (c == 10) evt[W + 2] = 1'b1; else evt = '0;
            @(negedge clk);
        end
        chk(n == PW, "R4", "total low cycles", n, PW);
        chk(stat[W + 2] == 1'b1, "R4", "late event latched", stat[W + 2], 1);

        // R5, R7, R6: level mode without auto-clear
        do_reset();
        cfg_level = 1'b1; cfg_autoclr = 1'b0;
        fire(1, 7);
        repeat (50) @(negedge clk);
        chk(irq_n == 1'b0, "R5", "level held", irq_n, 0);
        rd(1);
        chk(stat[W + 7] == 1'b1, "R7", "read keeps bit", stat[W + 7], 1);
        chk(irq_n == 1'b0, "R7", "read without autoclr keeps level", irq_n, 0);
        irq_rst_stb = 1'b1; @(negedge clk); irq_rst_stb = 1'b0;
        chk(irq_n == 1'b1, "R6", "sw reset releases", irq_n, 1);
        // R6 collision: reset strobe and event together
        fire(0, 1);
        irq_rst_stb = 1'b1; evt[4] = 1'b1;
        @(negedge clk);
        irq_rst_stb = 1'b0; evt = '0;
        chk(irq_n == 1'b0, "R6", "event wins over sw reset", irq_n, 0);

        // R8: auto-clear needs both registers read
        do_reset();
        cfg_level = 1'b1; cfg_autoclr = 1'b1;
        evt[2] = 1'b1; evt[W + 9] = 1'b1;
        @(negedge clk); evt = '0;
        chk(irq_n == 1'b0, "R8", "level set", irq_n, 0);
        rd(0);
        chk(stat[W-1:0] == '0, "R7", "autoclr read empties reg0", stat[W-1:0], 0);
        chk(irq_n == 1'b0, "R8", "one of two read keeps low", irq_n, 0);
        rd(1);
        chk(stat == '0, "R7", "autoclr read empties reg1", stat, 0);
        chk(irq_n == 1'b1, "R8", "all read releases", irq_n, 1);

        // R9: event and auto-clear read of the same register together
        fire(0, 6);
        rd_stb[0] = 1'b1; evt[11] = 1'b1;
        @(negedge clk);
        rd_stb = '0; evt = '0;
        chk(stat[W-1:0] == 16'h0800, "R9", "new bit survives read", stat[W-1:0], 16'h0800);
        chk(irq_n == 1'b0, "R9", "level stays low", irq_n, 0);
        rd(0);
        chk(irq_n == 1'b1, "R8", "final read releases", irq_n, 1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule